// File: doc/BRIEF.md
# Segment Selector Descriptor Fetcher

This block turns a 16-bit segment selector into the segment it names. The selector's table-indicator bit chooses between the global and the local descriptor table, each described by a base address and a byte limit held at the block's inputs. The 13-bit index times eight gives the descriptor's byte offset in that table. The block reads the 8-byte descriptor as two 32-bit words over a plain request/acknowledge memory port. It then gathers the scattered base and limit pieces, scales the limit by the granularity bit and reports the privilege level, type, flag nibble and a system-descriptor class.

A load strobe starts a lookup. Before any memory traffic, the selector is screened: a null selector in the global table, or an index whose descriptor would run past the table limit, ends the lookup at once with a fault. A fetched descriptor that is not present, or a task-state or table descriptor found in the local table, also ends with a fault. A one-cycle done pulse marks the end of every lookup. The valid or fault level that goes with it is held until the next load.

Top module: `seg_desc_fetch`

## Requirements
- R1: While reset is asserted and after it is released, done, valid, fault and rdReq are low until a load is accepted.
- R2: A selector with bit 2 clear reads from gdtBase and one with bit 2 set reads from ldtBase. The first read is at base + index*8 (index = selector bits 15..3) and the second at that address + 4. rdReq and rdAddr hold steady until rdAck.
- R3: segBase is formed from the low word bits 31..16 (base 15..0), high word bits 7..0 (base 23..16) and high word bits 31..24 (base 31..24).
- R4: The 20-bit raw limit is low word bits 15..0 with high word bits 19..16 above them. When the granularity bit (high word bit 23) is 1, segLimit is raw*4096 + 4095; otherwise it is the raw limit.
- R5: segDpl is high word bits 14..13 and segType is high word bits 11..8. segFlags is high word bits 23..20. reqRpl equals bits 1..0 of the loaded selector.
- R6: A global-table selector with index 0 faults without any memory read. A local-table selector with index 0 is fetched normally.
- R7: If index*8 + 7 exceeds the selected table's limit, the lookup faults without any memory read. Exactly equal is accepted.
- R8: A descriptor whose present bit (high word bit 15) is 0 gives fault=1, valid=0.
- R9: descKind is 0 when the S bit (high word bit 12) is 1. With S=0 it is 2 for type 9 or 11, 3 for type 2, and 1 for any other type.
- R10: A descriptor with S=0 and type 2, 9 or 11 fetched through the local table faults. The same descriptors fetched through the global table are valid.
- R11: done is a single-cycle pulse. After a fetch it rises in the cycle right after the second read's acknowledge. After a selector fault it rises two cycles after the load is sampled.
- R12: valid and fault are never high together. Both are low while a lookup is in progress and hold their value after done until the next load. A load strobe during a lookup is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Start a lookup of `selector` |
| selector | input | 16 | Segment selector |
| gdtBase | input | ADDR_W | Global table base address |
| gdtLimit | input | TLIM_W | Global table byte limit |
| ldtBase | input | ADDR_W | Local table base address |
| ldtLimit | input | TLIM_W | Local table byte limit |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | ADDR_W | Memory read byte address |
| rdAck | input | 1 | Read acknowledge, data valid in the same cycle |
| rdData | input | 32 | Read data |
| done | output | 1 | Lookup finished pulse |
| valid | output | 1 | Last lookup produced a usable segment |
| fault | output | 1 | Last lookup faulted |
| segBase | output | 32 | Assembled segment base |
| segLimit | output | 20+GRAN_SHIFT | Scaled segment limit |
| segDpl | output | 2 | Descriptor privilege level |
| segType | output | 4 | Descriptor type field |
| segFlags | output | 4 | Granularity, operand size, reserved, available bits |
| descKind | output | 2 | 0 code/data, 1 other system, 2 task state, 3 local table |
| reqRpl | output | 2 | Requested privilege level of the selector |

## Verification
The hardest case to reach is a load strobe that arrives in the middle of a fetch. The stimulus raises a second strobe with a different selector while the first read is still outstanding. It then checks that the finished result belongs to the first selector and that no second done pulse follows. The other hard case is the table-limit boundary. Descriptors are placed at the exact last slot of each table and one slot beyond it, so the accept case and the no-read fault case are both observed through the read count.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDLO,
    ST_RDHI,
    ST_FIN
  } sdfState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSel;
    logic chkFail;
    logic capLo;
    logic capHi;
    logic hiWord;
  } sdfStrobe_t;

  typedef enum logic [1:0] {
    KIND_SEG = 2'd0,
    KIND_SYS = 2'd1,
    KIND_TSS = 2'd2,
    KIND_TBL = 2'd3
  } descKind_t;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       preFault,
  input  logic       rdAck,
  output sdfStrobe_t stb,
  output logic       rdReq,
  output logic       done,
  output logic       busy
);

  sdfState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    rdReq    = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (loadStb) begin
          stb.latchSel = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (preFault) begin
          stb.chkFail = 1'b1;
          stateNxt    = ST_FIN;
        end else begin
          stateNxt = ST_RDLO;
        end
      end
      ST_RDLO: begin
        rdReq = 1'b1;
        if (rdAck) begin
          stb.capLo = 1'b1;
          stateNxt  = ST_RDHI;
        end
      end
      ST_RDHI: begin
        rdReq      = 1'b1;
        stb.hiWord = 1'b1;
        if (rdAck) begin
          stb.capHi = 1'b1;
          stateNxt  = ST_FIN;
        end
      end
      ST_FIN: begin
        done = 1'b1;
        if (loadStb) begin
          stb.latchSel = 1'b1;
          stateNxt     = ST_CHECK;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_CHECK) || (state == ST_RDLO) || (state == ST_RDHI);

endmodule

// File: rtl/sdf_dp.sv
module sdf_dp
  import sdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  sdfStrobe_t          stb,
  input  logic [SEL_W-1:0]    selector,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [TLIM_W-1:0]   gdtLimit,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [TLIM_W-1:0]   ldtLimit,
  input  logic [WORD_W-1:0]   rdData,
  output logic                preFault,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   loWord,
  output logic [WORD_W-1:0]   hiWord,
  output logic                selTi,
  output logic [1:0]          selRpl,
  output logic [SEL_W-1:0]    selLatched,
  output logic                fetched,
  output logic                earlyFault
);

  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = (TLIM_W > SEL_W) ? TLIM_W : SEL_W;

  logic [SEL_W-1:0]  selReg;
  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] tblBase;
  logic [TLIM_W-1:0] tblLimit;
  logic [SEL_W-1:0]  lastByte;
  logic              isNull;
  logic              overLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg     <= '0;
      loWord     <= '0;
      hiWord     <= '0;
      fetched    <= 1'b0;
      earlyFault <= 1'b0;
    end else begin
      if (stb.latchSel) begin
        selReg     <= selector;
        fetched    <= 1'b0;
        earlyFault <= 1'b0;
      end
      if (stb.chkFail) earlyFault <= 1'b1;
      if (stb.capLo)   loWord     <= rdData;
      if (stb.capHi) begin
        hiWord  <= rdData;
        fetched <= 1'b1;
      end
    end
  end

  assign selIdx   = selReg[SEL_W-1:3];
  assign selTi    = selReg[2];
  assign selRpl   = selReg[1:0];
  assign selLatched = selReg;

  assign tblBase  = selTi ? ldtBase  : gdtBase;
  assign tblLimit = selTi ? ldtLimit : gdtLimit;

  assign lastByte  = {selIdx, 3'b111};
  assign isNull    = !selTi && (selIdx == '0);
  assign overLimit = CMP_W'(lastByte) > CMP_W'(tblLimit);
  assign preFault  = isNull || overLimit;

  // word select goes in address bit 2
  assign rdAddr = tblBase + ADDR_W'({selIdx, stb.hiWord, 2'b00});

endmodule

// File: rtl/sdf_cls.sv
module sdf_cls
  import sdf_pkg::*;
#(
  parameter int GRAN_SHIFT = 12,
  localparam int LIM_OUT_W = 20 + GRAN_SHIFT
) (
  input  logic [WORD_W-1:0]    loWord,
  input  logic [WORD_W-1:0]    hiWord,
  input  logic                 selTi,
  output logic [31:0]          segBase,
  output logic [LIM_OUT_W-1:0] segLimit,
  output logic [1:0]           segDpl,
  output logic [3:0]           segType,
  output logic [3:0]           segFlags,
  output descKind_t            kind,
  output logic                 descFault
);

  logic [19:0] rawLimit;
  logic        gran;
  logic        present;
  logic        codeData;
  logic        ldtOnly;

  assign segBase  = {hiWord[31:24], hiWord[7:0], loWord[31:16]};
  assign rawLimit = {hiWord[19:16], loWord[15:0]};
  assign segFlags = hiWord[23:20];
  assign gran     = hiWord[23];
  assign present  = hiWord[15];
  assign segDpl   = hiWord[14:13];
  assign codeData = hiWord[12];
  assign segType  = hiWord[11:8];

  generate
    if (GRAN_SHIFT > 0) begin : g_scale
      assign segLimit = gran ? {rawLimit, {GRAN_SHIFT{1'b1}}} : LIM_OUT_W'(rawLimit);
    end else begin : g_noscale
      assign segLimit = rawLimit;
    end
  endgenerate

  always_comb begin
    kind = KIND_SEG;
    if (!codeData) begin
      unique case (segType)
        4'd9, 4'd11: kind = KIND_TSS;
        4'd2:        kind = KIND_TBL;
        default:     kind = KIND_SYS;
      endcase
    end
  end

  assign ldtOnly   = (kind == KIND_TSS) || (kind == KIND_TBL);
  assign descFault = !present || (selTi && ldtOnly);

endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import sdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TLIM_W     = 16,
  parameter int GRAN_SHIFT = 12,
  localparam int LIM_OUT_W = 20 + GRAN_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStb,
  input  logic [15:0]          selector,
  input  logic [ADDR_W-1:0]    gdtBase,
  input  logic [TLIM_W-1:0]    gdtLimit,
  input  logic [ADDR_W-1:0]    ldtBase,
  input  logic [TLIM_W-1:0]    ldtLimit,
  output logic                 rdReq,
  output logic [ADDR_W-1:0]    rdAddr,
  input  logic                 rdAck,
  input  logic [31:0]          rdData,
  output logic                 done,
  output logic                 valid,
  output logic                 fault,
  output logic [31:0]          segBase,
  output logic [LIM_OUT_W-1:0] segLimit,
  output logic [1:0]           segDpl,
  output logic [3:0]           segType,
  output logic [3:0]           segFlags,
  output logic [1:0]           descKind,
  output logic [1:0]           reqRpl
);

  sdfStrobe_t        stb;
  logic              preFault;
  logic              busy;
  logic [31:0]       loWord;
  logic [31:0]       hiWord;
  logic              selTi;
  logic [15:0]       selLatched;
  logic              fetched;
  logic              earlyFault;
  logic              descFault;
  descKind_t         kind;

  sdf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadStb  (loadStb),
    .preFault (preFault),
    .rdAck    (rdAck),
    .stb      (stb),
    .rdReq    (rdReq),
    .done     (done),
    .busy     (busy)
  );

  sdf_dp #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .selector   (selector),
    .gdtBase    (gdtBase),
    .gdtLimit   (gdtLimit),
    .ldtBase    (ldtBase),
    .ldtLimit   (ldtLimit),
    .rdData     (rdData),
    .preFault   (preFault),
    .rdAddr     (rdAddr),
    .loWord     (loWord),
    .hiWord     (hiWord),
    .selTi      (selTi),
    .selRpl     (reqRpl),
    .selLatched (selLatched),
    .fetched    (fetched),
    .earlyFault (earlyFault)
  );

  sdf_cls #(.GRAN_SHIFT(GRAN_SHIFT)) u_cls (
    .loWord    (loWord),
    .hiWord    (hiWord),
    .selTi     (selTi),
    .segBase   (segBase),
    .segLimit  (segLimit),
    .segDpl    (segDpl),
    .segType   (segType),
    .segFlags  (segFlags),
    .kind      (kind),
    .descFault (descFault)
  );

  assign descKind = kind;
  assign fault    = earlyFault || (fetched && descFault);
  assign valid    = fetched && !earlyFault && !descFault;

endmodule

// File: rtl/sdf_chk.sv
module sdf_chk #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              done,
  input logic              valid,
  input logic              fault,
  input logic              busy,
  input logic [15:0]       selLatched,
  input logic [TLIM_W-1:0] gdtLimit,
  input logic [TLIM_W-1:0] ldtLimit
);

  logic [31:0] endByte;
  logic [31:0] tblLim;
  assign endByte = 32'({selLatched[15:3], 3'b111});
  assign tblLim  = selLatched[2] ? 32'(ldtLimit) : 32'(gdtLimit);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && valid) |-> $past(rdReq && rdAck));

  // R12
  valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(valid && fault));

  // R12
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!valid && !fault));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R7
  read_in_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (endByte <= tblLim));

  // R6
  no_null_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !(!selLatched[2] && selLatched[15:3] == 13'd0));

endmodule

bind seg_desc_fetch sdf_chk #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdReq      (rdReq),
  .rdAck      (rdAck),
  .rdAddr     (rdAddr),
  .done       (done),
  .valid      (valid),
  .fault      (fault),
  .busy       (busy),
  .selLatched (selLatched),
  .gdtLimit   (gdtLimit),
  .ldtLimit   (ldtLimit)
);

// File: tb/sim_seg_desc_fetch.sv
module sim_seg_desc_fetch;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] selector = '0;
  logic [31:0] gdtBase = 32'h0000_0000;
  logic [15:0] gdtLimit = 16'h003F;
  logic [31:0] ldtBase = 32'h0000_0080;
  logic [15:0] ldtLimit = 16'h0027;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;
  logic        done, valid, fault;
  logic [31:0] segBase, segLimit;
  logic [1:0]  segDpl, descKind, reqRpl;
  logic [3:0]  segType, segFlags;

  seg_desc_fetch u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .selector(selector),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .done(done), .valid(valid), .fault(fault), .segBase(segBase),
    .segLimit(segLimit), .segDpl(segDpl), .segType(segType), .segFlags(segFlags),
    .descKind(descKind), .reqRpl(reqRpl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem [64];
  int          hsCnt = 0;
  int          reqCnt = 0;
  logic [31:0] addrLog [4];
  logic        doneAck = 1'b0;

  // memory model: acknowledge one cycle after a request is seen
  always @(negedge clk) begin
    if (rdAck) hsCnt = hsCnt + 1;
    if (done) doneAck = rdAck;
    if (rdReq && !rdAck) begin
      addrLog[reqCnt % 4] = rdAddr;
      reqCnt = reqCnt + 1;
      rdData <= mem[rdAddr[7:2]];
      rdAck  <= 1'b1;
    end else begin
      rdAck <= 1'b0;
    end
  end

  function automatic logic [63:0] mkDesc(logic [31:0] base, logic [19:0] lim,
      logic [3:0] typ, logic s, logic [1:0] dpl, logic p, logic g, logic db);
    return {base[31:24], g, db, 1'b0, 1'b0, lim[19:16], p, dpl, s, typ,
            base[23:16], base[15:0], lim[15:0]};
  endfunction

  task automatic putDesc(int byteAddr, logic [63:0] d);
    mem[byteAddr/4]     = d[31:0];
    mem[byteAddr/4 + 1] = d[63:32];
  endtask

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] scaleLim(logic [19:0] lim, logic g);
    return g ? {lim, 12'hFFF} : {12'h0, lim};
  endfunction

  int          rCyc, rReads;
  logic [31:0] rAddr0, rAddr1;

  task automatic fetch(logic [15:0] sel);
    int h0, q0;
    h0 = hsCnt; q0 = reqCnt;
    @(negedge clk); #1;
    selector = sel; loadStb = 1'b1;
    @(negedge clk); #1;
    loadStb = 1'b0;
    rCyc = 1;
    while (!done && rCyc < 64) begin
      @(negedge clk); #1;
      rCyc++;
    end
    rReads = hsCnt - h0;
    rAddr0 = addrLog[q0 % 4];
    rAddr1 = addrLog[(q0 + 1) % 4];
  endtask

  task automatic expectSeg(string req, logic [31:0] b, logic [19:0] lim, logic g,
      logic [1:0] dpl, logic [3:0] typ, logic [1:0] kind, logic [1:0] rpl);
    chk(valid && !fault, req, {valid, fault}, 2'b10);
    chk(segBase == b, req, segBase, b);
    chk(segLimit == scaleLim(lim, g), req, segLimit, scaleLim(lim, g));
    chk(segDpl == dpl, req, segDpl, dpl);
    chk(segType == typ, req, segType, typ);
    chk(descKind == kind, req, descKind, kind);
    chk(reqRpl == rpl, req, reqRpl, rpl);
  endtask

  task automatic testReset();
    chk(!done && !valid && !fault && !rdReq, "R1 in reset", {done, valid, fault, rdReq}, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!done && !valid && !fault && !rdReq, "R1 after reset", {done, valid, fault, rdReq}, 0);
  endtask

  task automatic testGdtPlain();
    fetch({13'd1, 1'b0, 2'd2});
    chk(rAddr0 == 32'h08 && rAddr1 == 32'h0C, "R2 gdt addresses", {rAddr0, rAddr1}, 64'h8_0000000C);
    chk(rReads == 2, "R2 read count", rReads, 2);
    expectSeg("R3 R4 R5 gdt code", 32'h12345678, 20'hABCDE, 1'b0, 2'd0, 4'hA, 2'd0, 2'd2);
    chk(segFlags == 4'b0100, "R5 flags", segFlags, 4'b0100);
    chk(rCyc == 5 && doneAck, "R11 done after second ack", {rCyc, doneAck}, {5, 1'b1});
    @(negedge clk); #1;
    chk(!done, "R11 done single pulse", done, 0);
    chk(valid && segBase == 32'h12345678, "R12 result held", segBase, 32'h12345678);
  endtask

  task automatic testGran();
    fetch({13'd2, 1'b0, 2'd3});
    expectSeg("R4 granular limit", 32'hDEADBEEF, 20'h0000F, 1'b1, 2'd3, 4'h2, 2'd0, 2'd3);
    fetch({13'd7, 1'b0, 2'd0});
    expectSeg("R7 last slot R9 other system", 32'h0BADF00D, 20'h12345, 1'b1, 2'd1, 4'hC, 2'd1, 2'd0);
  endtask

  task automatic testLdt();
    fetch({13'd0, 1'b1, 2'd1});
    chk(rReads == 2 && rAddr0 == 32'h80, "R6 ldt index 0 fetched", rAddr0, 32'h80);
    expectSeg("R6 ldt index 0", 32'h11112222, 20'h00100, 1'b0, 2'd1, 4'h3, 2'd0, 2'd1);
    fetch({13'd3, 1'b1, 2'd0});
    chk(rAddr0 == 32'h98 && rAddr1 == 32'h9C, "R2 ldt addresses", {rAddr0, rAddr1}, 64'h98_0000009C);
    expectSeg("R2 ldt data", 32'hCAFE0000, 20'h00FFF, 1'b0, 2'd2, 4'h2, 2'd0, 2'd0);
    fetch({13'd4, 1'b1, 2'd0});
    expectSeg("R7 ldt exact limit", 32'h55667788, 20'h00001, 1'b0, 2'd0, 4'h3, 2'd0, 2'd0);
  endtask

  task automatic testSelFaults();
    fetch({13'd0, 1'b0, 2'd0});
    chk(fault && !valid, "R6 null selector fault", {fault, valid}, 2'b10);
    chk(rReads == 0, "R6 null no read", rReads, 0);
    chk(rCyc == 2 && !doneAck, "R11 early done timing", rCyc, 2);
    fetch({13'd8, 1'b0, 2'd0});
    chk(fault && rReads == 0, "R7 gdt over limit", {fault, rReads}, {1'b1, 0});
    fetch({13'd5, 1'b1, 2'd0});
    chk(fault && rReads == 0, "R7 ldt over limit", {fault, rReads}, {1'b1, 0});
  endtask

  task automatic testDescFaults();
    fetch({13'd6, 1'b0, 2'd0});
    chk(fault && !valid && rReads == 2, "R8 not present", {fault, valid}, 2'b10);
    fetch({13'd3, 1'b0, 2'd0});
    expectSeg("R9 R10 tss in gdt", 32'h00001000, 20'h00067, 1'b0, 2'd0, 4'h9, 2'd2, 2'd0);
    fetch({13'd4, 1'b0, 2'd0});
    expectSeg("R9 busy tss in gdt", 32'h00002000, 20'h00067, 1'b0, 2'd0, 4'hB, 2'd2, 2'd0);
    fetch({13'd5, 1'b0, 2'd0});
    expectSeg("R9 R10 table desc in gdt", 32'h00003000, 20'h0003F, 1'b0, 2'd0, 4'h2, 2'd3, 2'd0);
    fetch({13'd1, 1'b1, 2'd0});
    chk(fault && !valid, "R10 tss in ldt", {fault, valid}, 2'b10);
    fetch({13'd2, 1'b1, 2'd0});
    chk(fault && !valid, "R10 table desc in ldt", {fault, valid}, 2'b10);
  endtask

  task automatic testBusyLoad();
    int d0, cyc;
    @(negedge clk); #1;
    selector = {13'd1, 1'b0, 2'd0}; loadStb = 1'b1;
    @(negedge clk); #1;
    loadStb = 1'b0;
    chk(!valid && !fault, "R12 cleared while busy", {valid, fault}, 0);
    @(negedge clk); #1;
    selector = {13'd2, 1'b0, 2'd3}; loadStb = 1'b1;
    @(negedge clk); #1;
    loadStb = 1'b0;
    cyc = 0;
    while (!done && cyc < 64) begin @(negedge clk); #1; cyc++; end
    chk(segBase == 32'h12345678, "R12 load during busy ignored", segBase, 32'h12345678);
    d0 = 0;
    repeat (6) begin @(negedge clk); #1; if (done) d0++; end
    chk(d0 == 0 && valid, "R12 no second lookup", d0, 0);
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 32'h0;
    putDesc(8'h08, mkDesc(32'h12345678, 20'hABCDE, 4'hA, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1));
    putDesc(8'h10, mkDesc(32'hDEADBEEF, 20'h0000F, 4'h2, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1));
    putDesc(8'h18, mkDesc(32'h00001000, 20'h00067, 4'h9, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'h20, mkDesc(32'h00002000, 20'h00067, 4'hB, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'h28, mkDesc(32'h00003000, 20'h0003F, 4'h2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'h30, mkDesc(32'h00004000, 20'h00FFF, 4'h2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0));
    putDesc(8'h38, mkDesc(32'h0BADF00D, 20'h12345, 4'hC, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0));
    putDesc(8'h80, mkDesc(32'h11112222, 20'h00100, 4'h3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0));
    putDesc(8'h88, mkDesc(32'h00005000, 20'h00067, 4'h9, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'h90, mkDesc(32'h00006000, 20'h0003F, 4'h2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'h98, mkDesc(32'hCAFE0000, 20'h00FFF, 4'h2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0));
    putDesc(8'hA0, mkDesc(32'h55667788, 20'h00001, 4'h3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0));
    putDesc(8'hA8, mkDesc(32'h99999999, 20'h00001, 4'h3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0));

    repeat (2) @(negedge clk);
    #1;
    testReset();
    testGdtPlain();
    testGran();
    testLdt();
    testSelFaults();
    testDescFaults();
    testBusyLoad();

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule